// File: doc/BRIEF.md
# Press-Toggle Pixel Matrix Scanner

This block looks after an 8x8 pressure-sensing pixel matrix. The matrix also shows a light pattern. The block keeps an on/off image of the matrix, and each new press on a pixel flips that pixel's stored state. A second map records which pixels are currently held down. A press that is kept down across several scans therefore flips its pixel only once. The status bit clears when the press is released.

While the mode input is low, the block alternates between two passes:

- **Sense pass.** The block selects one row at a time and reads the eight column inputs, one pixel per clock. It visits row 0, column 0 first, steps through the columns, then moves to the next row.
- **Drive pass.** The block visits the pixels again in the same order. For each pixel that is on, it raises that pixel's column line and activates its row sink line, holding both for a set number of clocks. It never lights more than one pixel at a time.

While mode is high, the block idles with every line released and leaves its image untouched. In that mode another agent owns the display.

Top module: `press_toggle_scanner`

## Requirements
- R1: A synchronous active-high reset clears the image and the held-status maps. While reset is asserted, every output is zero.
- R2: The sense pass works as follows:
  - It begins on the first clock after mode is seen low.
  - It lasts ROWS*COLS cycles, one pixel per cycle, in row-major order starting at row 0, column 0.
  - During each cycle, `row_sel_o` is one-hot on the current row (bit r = row r), and the drive outputs are zero.
  - The column input sampled for pixel (r,c) is `col_sense_i[c]`.
- R3: When a pixel is sensed pressed and its status bit is clear, its image bit is inverted: an off pixel turns on and an on pixel turns off. Its status bit is then set.
- R4: When a pixel is sensed pressed with its status bit already set, its image bit does not change. When a pixel is sensed released, its status bit clears, so the next press toggles it again.
- R5: The drive pass follows immediately after the last sensed pixel. It visits pixels in the same row-major order:
  - A pixel that is on drives `col_drive_o[c]` and `row_sink_o[r]` high for exactly HOLD_CYCLES cycles.
  - A pixel that is off takes one cycle with all lines low.
  - After the last pixel, the next sense pass starts.
- R6: At most one column drive line and one row sink line are active at once, always together. No drive line is active while a row is selected for sensing.
- R7: Mode high has the following effects:
  - All outputs go to zero on the next clock.
  - Column inputs are ignored and the image is kept.
  - When mode returns low, the sense pass restarts at pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Low: scan and toggle; high: idle, lines released |
| col_sense_i | input | COLS | Column sense inputs for the selected row, bit c = column c |
| row_sel_o | output | ROWS | One-hot sense row select, bit r = row r |
| col_drive_o | output | COLS | Column source line of the lit pixel |
| row_sink_o | output | ROWS | Row sink enable (high = row grounded) of the lit pixel |

## Verification
The bench builds the block at 8x8 with HOLD_CYCLES set to 3 rather than the default 2. With that setting, a lit pixel's dwell is clearly distinguishable from that of an off pixel. An error in the hold count also shows up directly as a shifted drive pass. Because each pass length depends on how many pixels are lit, the bench's computed pass timing checks the image and the sequencing together. The test patterns range from an empty image to a fully inverted one. The bench also aborts a scan mid-pass by raising mode, and asserts reset while a key is held.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SENSE = 2'd1,
    PH_DRIVE = 2'd2
  } phase_e;

endpackage

// File: rtl/pts_scan_seq.sv
module pts_scan_seq
  import pts_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int HOLD_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_i,
  input  logic                     lit_cur_i,
  output phase_e                   phase_q,
  output logic [$clog2(ROWS)-1:0]  row_q,
  output logic [$clog2(COLS)-1:0]  col_q,
  output phase_e                   phase_d,
  output logic [$clog2(ROWS)-1:0]  row_d,
  output logic [$clog2(COLS)-1:0]  col_d
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int IDX_W  = $clog2(ROWS * COLS);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [HOLD_W-1:0] LAST_HOLD = HOLD_W'(HOLD_CYCLES - 1);

  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              last_px;
  logic [ROW_W-1:0]  row_step;
  logic [COL_W-1:0]  col_step;
  logic [IDX_W-1:0]  lin_q;

  assign last_px = (row_q == LAST_ROW) && (col_q == LAST_COL);
  assign lin_q   = IDX_W'(row_q) * IDX_W'(COLS) + IDX_W'(col_q);

  // row-major successor of the current pixel
  always_comb begin
    if (col_q == LAST_COL) begin
      col_step = '0;
      row_step = row_q + 1'b1;
    end else begin
      col_step = col_q + 1'b1;
      row_step = row_q;
    end
  end

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    col_d   = col_q;
    hold_d  = hold_q;
    case (phase_q)
      PH_IDLE: begin
        if (!mode_i) begin
          phase_d = PH_SENSE;
          row_d   = '0;
          col_d   = '0;
          hold_d  = '0;
        end
      end
      PH_SENSE: begin
        if (mode_i) begin
          phase_d = PH_IDLE;
        end else if (last_px) begin
          phase_d = PH_DRIVE;
          row_d   = '0;
          col_d   = '0;
          hold_d  = '0;
        end else begin
          row_d = row_step;
          col_d = col_step;
        end
      end
      PH_DRIVE: begin
        if (mode_i) begin
          phase_d = PH_IDLE;
        end else if (lit_cur_i && (hold_q != LAST_HOLD)) begin
          hold_d = hold_q + 1'b1;
        end else if (last_px) begin
          phase_d = PH_SENSE;
          row_d   = '0;
          col_d   = '0;
          hold_d  = '0;
        end else begin
          row_d  = row_step;
          col_d  = col_step;
          hold_d = '0;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      col_q   <= col_d;
      hold_q  <= hold_d;
    end
  end

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SENSE && !mode_i && !last_px)
      |=> (phase_q == PH_SENSE && lin_q == $past(lin_q) + IDX_W'(1)));

  // R5
  lit_dwell_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DRIVE && !mode_i && lit_cur_i && hold_q != LAST_HOLD)
      |=> (phase_q == PH_DRIVE && $stable(lin_q)));

endmodule

// File: rtl/pts_toggle_map.sv
module pts_toggle_map #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sense_en_i,
  input  logic                    key_i,
  input  logic [$clog2(ROWS)-1:0] row_i,
  input  logic [$clog2(COLS)-1:0] col_i,
  input  logic [$clog2(ROWS)-1:0] rd_row_i,
  input  logic [$clog2(COLS)-1:0] rd_col_i,
  output logic                    cur_bit_o,
  output logic                    rd_bit_o
);

  // one word per row, bit c of a word = column c
  logic [ROWS-1:0][COLS-1:0] img;
  logic [ROWS-1:0][COLS-1:0] held;
  logic [ROWS-1:0][COLS-1:0] sel_mask;
  logic                      held_cur;

  assign cur_bit_o = img[row_i][col_i];
  assign rd_bit_o  = img[rd_row_i][rd_col_i];
  assign held_cur  = held[row_i][col_i];

  always_comb begin
    sel_mask = '0;
    sel_mask[row_i][col_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      img  <= '0;
      held <= '0;
    end else if (sense_en_i) begin
      if (key_i) begin
        held[row_i][col_i] <= 1'b1;
        if (!held_cur) img[row_i][col_i] <= ~img[row_i][col_i];
      end else begin
        held[row_i][col_i] <= 1'b0;
      end
    end
  end

  // R3
  new_press_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (sense_en_i && key_i && !held_cur) |=> (img == ($past(img) ^ $past(sel_mask))));

  // R4
  held_press_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sense_en_i && key_i && held_cur) |=> $stable(img));

  // R7
  no_sense_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !sense_en_i |=> $stable(img));

endmodule

// File: rtl/pts_line_drive.sv
module pts_line_drive
  import pts_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  phase_e                  phase_d,
  input  logic [$clog2(ROWS)-1:0] row_d,
  input  logic [$clog2(COLS)-1:0] col_d,
  input  logic                    lit_d,
  output logic [ROWS-1:0]         row_sel_o,
  output logic [COLS-1:0]         col_drive_o,
  output logic [ROWS-1:0]         row_sink_o
);

  logic [ROWS-1:0] row_hot;
  logic [COLS-1:0] col_hot;
  logic            lit_now;

  assign row_hot = ROWS'(1) << row_d;
  assign col_hot = COLS'(1) << col_d;
  assign lit_now = (phase_d == PH_DRIVE) && lit_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel_o   <= '0;
      col_drive_o <= '0;
      row_sink_o  <= '0;
    end else begin
      row_sel_o   <= (phase_d == PH_SENSE) ? row_hot : '0;
      col_drive_o <= lit_now ? col_hot : '0;
      row_sink_o  <= lit_now ? row_hot : '0;
    end
  end

  // R6
  single_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_drive_o) && ($countones(col_drive_o) == $countones(row_sink_o)));

  // R6
  sense_drive_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !((|row_sel_o) && (|col_drive_o)));

endmodule

// File: rtl/press_toggle_scanner.sv
module press_toggle_scanner #(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int HOLD_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic [COLS-1:0] col_sense_i,
  output logic [ROWS-1:0] row_sel_o,
  output logic [COLS-1:0] col_drive_o,
  output logic [ROWS-1:0] row_sink_o
);

  import pts_pkg::*;

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  phase_e             phase_q, phase_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic               lit_cur, lit_next;
  logic               sense_en;
  logic               key;

  assign sense_en = (phase_q == PH_SENSE) && !mode_i;
  assign key      = col_sense_i[col_q];

  pts_scan_seq #(
    .ROWS(ROWS), .COLS(COLS), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .mode_i(mode_i), .lit_cur_i(lit_cur),
    .phase_q(phase_q), .row_q(row_q), .col_q(col_q),
    .phase_d(phase_d), .row_d(row_d), .col_d(col_d)
  );

  pts_toggle_map #(
    .ROWS(ROWS), .COLS(COLS)
  ) u_map (
    .clk(clk), .rst(rst), .sense_en_i(sense_en), .key_i(key),
    .row_i(row_q), .col_i(col_q), .rd_row_i(row_d), .rd_col_i(col_d),
    .cur_bit_o(lit_cur), .rd_bit_o(lit_next)
  );

  pts_line_drive #(
    .ROWS(ROWS), .COLS(COLS)
  ) u_drive (
    .clk(clk), .rst(rst), .phase_d(phase_d), .row_d(row_d), .col_d(col_d),
    .lit_d(lit_next), .row_sel_o(row_sel_o), .col_drive_o(col_drive_o),
    .row_sink_o(row_sink_o)
  );

endmodule

// File: tb/press_toggle_scanner_test.sv
module press_toggle_scanner_test;

  localparam int R = 8;
  localparam int C = 8;
  localparam int H = 3;
  localparam int N = R * C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode = 1'b1;
  logic [C-1:0] col_sense;
  logic [R-1:0] row_sel, row_sink;
  logic [C-1:0] col_drive;
  logic [C-1:0] pressed [R];

  logic [N-1:0] m_img  = '0;
  logic [N-1:0] m_held = '0;
  logic [N-1:0] exp_q [$];
  string        pass_tag = "R2";
  bit           mon_en = 1'b0;
  bit           done = 1'b0;
  int           errs = 0;
  int           checks = 0;

  always #5 clk = ~clk;

  // key matrix: the selected row's pressed keys appear on the columns
  always_comb begin
    col_sense = '0;
    for (int r = 0; r < R; r++) if (row_sel[r]) col_sense = col_sense | pressed[r];
  end

  press_toggle_scanner #(.ROWS(R), .COLS(C), .HOLD_CYCLES(H)) uut (
    .clk(clk), .rst(rst), .mode_i(mode), .col_sense_i(col_sense),
    .row_sel_o(row_sel), .col_drive_o(col_drive), .row_sink_o(row_sink)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic clear_press();
    for (int r = 0; r < R; r++) pressed[r] = '0;
  endtask

  task automatic press_px(input int r, input int c);
    pressed[r][c] = 1'b1;
  endtask

  // reference model of the sense pass over the first `upto` pixels
  task automatic model_sense(input int upto);
    for (int i = 0; i < upto; i++) begin
      if (pressed[i / C][i % C]) begin
        if (!m_held[i]) m_img[i] = ~m_img[i];
        m_held[i] = 1'b1;
      end else begin
        m_held[i] = 1'b0;
      end
    end
  endtask

  task automatic outputs_idle(input string req, input string what);
    check(row_sel == '0 && col_drive == '0 && row_sink == '0, req, what,
          {40'd0, row_sel, col_drive, row_sink}, 64'd0);
  endtask

  // driver: one sense pass plus one drive pass, then back to idle
  task automatic scan_pass(input string tag);
    pass_tag = tag;
    model_sense(N);
    exp_q.push_back(m_img);
    mode = 1'b0;
    repeat (N + N + (H - 1) * $countones(m_img)) @(negedge clk);
    mode = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: follows one pass and compares against the queued image
  task automatic run_pass();
    bit           ok = 1'b1;
    logic [63:0]  bad_act = '0, bad_exp = '0;
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      if (row_sel !== (R'(1) << (i / C)) || col_drive !== '0 || row_sink !== '0) begin
        if (ok) begin
          bad_act = {40'd0, row_sel, col_drive, row_sink};
          bad_exp = {40'd0, R'(1) << (i / C), 16'd0};
        end
        ok = 1'b0;
      end
    end
    check(ok, "R2", {pass_tag, " sense order"}, bad_act, bad_exp);
    if (exp_q.size() == 0) begin
      check(1'b0, "R5", {pass_tag, " no expected image queued"}, 64'd0, 64'd1);
      return;
    end
    e = exp_q.pop_front();
    for (int i = 0; i < N; i++) begin
      bit          px_ok = 1'b1;
      logic [63:0] act = '0;
      logic [63:0] exp = '0;
      if (e[i]) begin
        exp = {40'd0, 8'd0, C'(1) << (i % C), R'(1) << (i / C)};
        for (int h = 0; h < H; h++) begin
          @(negedge clk);
          if (col_drive !== (C'(1) << (i % C)) || row_sink !== (R'(1) << (i / C)) ||
              row_sel !== '0) begin
            px_ok = 1'b0;
            act = {40'd0, row_sel, col_drive, row_sink};
          end
        end
        check(px_ok, "R5", $sformatf("%s lit pixel %0d", pass_tag, i), act, exp);
      end else begin
        @(negedge clk);
        act = {40'd0, row_sel, col_drive, row_sink};
        check(act == '0, "R6", $sformatf("%s dark pixel %0d", pass_tag, i), act, exp);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && row_sel != '0) run_pass();
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    clear_press();
    mode = 1'b0;
    // R1: outputs stay low while reset is held, even with mode low
    repeat (3) begin
      @(negedge clk);
      outputs_idle("R1", "outputs during reset");
    end
    mode = 1'b1;
    rst  = 1'b0;
    @(negedge clk);
    outputs_idle("R7", "idle after reset");
    mon_en = 1'b1;

    scan_pass("R1 empty image");

    // R3: three new presses turn pixels on
    press_px(0, 0); press_px(3, 5); press_px(7, 7);
    scan_pass("R3 first presses");

    // R4: same keys still held, nothing flips
    scan_pass("R4 held keys");
    clear_press();
    scan_pass("R4 release");

    // R3: pressing an on pixel turns it off, another turns on
    press_px(3, 5); press_px(1, 2);
    scan_pass("R3 toggle off and on");

    // R7: mode high ignores every key and keeps lines low
    for (int r = 0; r < R; r++) pressed[r] = '1;
    repeat (20) begin
      @(negedge clk);
      outputs_idle("R7", "mode high with keys down");
    end
    clear_press();
    scan_pass("R7 keys ignored while idle");

    // R7: abort a sense pass mid-way; only pixels 0..28 are sensed
    mon_en = 1'b0;
    press_px(0, 3); press_px(5, 1);
    mode = 1'b0;
    repeat (30) @(negedge clk);
    mode = 1'b1;
    model_sense(29);
    @(negedge clk);
    outputs_idle("R7", "lines released one clock after mode high");
    repeat (2) @(negedge clk);
    clear_press();
    mon_en = 1'b1;
    scan_pass("R7 restart from pixel 0");

    // R3: every key pressed inverts the whole image
    for (int r = 0; r < R; r++) pressed[r] = '1;
    scan_pass("R3 invert all");
    clear_press();
    scan_pass("R4 release all");

    // R1: reset while a key is held clears image and status
    press_px(2, 2);
    scan_pass("R4 hold before reset");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_img  = '0;
    m_held = '0;
    @(negedge clk);
    outputs_idle("R1", "outputs after reset");
    scan_pass("R1 status cleared by reset");

    clear_press();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all queued images consumed", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule